// File: doc/BRIEF.md
# Bridge Forwarding Window Decoder

This block decides whether a bridge between two buses passes an access from its primary side down to its secondary side. The surrounding logic holds the bridge's type-1 header values. This block receives those values as plain inputs:
- the packed I/O, memory and prefetchable base and limit fields;
- their upper-address extensions;
- the command-register space enables;
- the legacy display (VGA) forwarding enable.

From these inputs it rebuilds each forwarding window as a full address range.

Each request carries an address and a space flag (I/O or memory). The block compares the request against every window and against the fixed legacy display ranges. One clock later it reports whether the access is claimed and which window claimed it. A forwarding engine uses the result to route the request, or to leave it on the primary bus.

Top module: `bridge_window_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next outputs are `rsp_valid`=0, `rsp_hit`=0 and `rsp_win`=0.
- R2: Each request is answered on the edge that samples `req_valid`=1, so the answer is visible one cycle after the request. A cycle with `req_valid`=0 gives `rsp_valid`=0, `rsp_hit`=0 and `rsp_win`=0.
- R3: I/O window range.
  - Base = `io_base_b[7:4]`<<12. Limit = (`io_limit_b[7:4]`<<12) | 0xFFF.
  - When a byte's low nibble equals 1, its 16-bit upper register fills bits 31:16. Otherwise those bits are 0.
  - Only `req_addr[31:0]` is compared for I/O requests.
- R4: Memory window range.
  - Base = `mem_base_w[15:4]`<<20. Limit = (`mem_limit_w[15:4]`<<20) | 0xFFFFF.
  - A memory request with any of `req_addr[63:32]` set never hits this window, and never hits the VGA memory range.
- R5: Prefetchable window range.
  - It is built like the memory window from `pf_base_w` and `pf_limit_w`.
  - When a word's low nibble equals 1, its 32-bit upper register fills bits 63:32 of that bound. Otherwise those bits are 0.
- R6: Space enables.
  - The I/O window only hits when `cmd_io_en`=1.
  - The memory and prefetchable windows only hit when `cmd_mem_en`=1.
  - A request of one space never hits a window of the other space.
- R7: A window whose limit is below its base hits no address.
- R8: With `vga_en`=1, three legacy ranges are forwarded whatever the command enables are:
  - I/O 0x3B0–0x3BB;
  - I/O 0x3C0–0x3DF;
  - memory 0xA0000–0xBFFFF.
- R9: Window codes and priority.
  - Codes: 0 none, 1 I/O window, 2 memory window, 3 prefetchable window, 4 VGA I/O, 5 VGA memory.
  - When windows overlap, priority is prefetchable, then memory, then VGA memory for memory requests. For I/O requests it is the I/O window, then VGA I/O.
  - `rsp_hit`=1 exactly when `rsp_win`≠0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_is_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr | input | 64 | Request address |
| cmd_io_en | input | 1 | Command I/O space enable |
| cmd_mem_en | input | 1 | Command memory space enable |
| vga_en | input | 1 | Legacy display range forwarding enable |
| io_base_b | input | 8 | Packed I/O base byte (low nibble = type) |
| io_limit_b | input | 8 | Packed I/O limit byte (low nibble = type) |
| io_base_hi | input | 16 | I/O base bits 31:16 |
| io_limit_hi | input | 16 | I/O limit bits 31:16 |
| mem_base_w | input | 16 | Packed memory base word |
| mem_limit_w | input | 16 | Packed memory limit word |
| pf_base_w | input | 16 | Packed prefetchable base word (low nibble = type) |
| pf_limit_w | input | 16 | Packed prefetchable limit word (low nibble = type) |
| pf_base_hi | input | 32 | Prefetchable base bits 63:32 |
| pf_limit_hi | input | 32 | Prefetchable limit bits 63:32 |
| rsp_valid | output | 1 | Answer present |
| rsp_hit | output | 1 | Access is forwarded downstream |
| rsp_win | output | 3 | Code of the claiming window |

## Verification
The hardest cases to reach from the ports are those where the upper extensions decide the result. Examples are a 32-bit I/O window above 64 KB, or a 64-bit prefetchable window above 4 GB. Another is an address equal to a padded limit while the upper register of the base differs from that of the limit. The stimulus programs the type nibbles and upper registers on purpose. It places addresses at base−1, base, limit and limit+1 of each window, and then changes only the type nibble to show that the upper register drops out. Overlap of the prefetchable and memory windows, and of the I/O window and the legacy display ranges, is set up on purpose to exercise the priority order. A randomized phase then compares every cycle against a behavioural model.

// File: rtl/bwd_pkg.sv
// Package for the bridge forwarding window decoder.
// Holds the address widths, the window codes, the legacy display ranges and
// the window descriptor type. It also holds the slot-to-code mapping used by
// the priority selector.
package bwd_pkg;
    parameter int ADDR_W     = 64;
    parameter int IO_W       = 32;
    parameter int MEM32_W    = 32;
    parameter int TYPE_W     = 4;
    parameter int IO_GRAN_W  = 12;
    parameter int MEM_GRAN_W = 20;
    parameter int CODE_W     = 3;
    parameter int NWIN       = 6;

    localparam int IO_FLD_W  = 8 - TYPE_W;
    localparam int IO_UP_W   = IO_W - IO_FLD_W - IO_GRAN_W;
    localparam int MEM_FLD_W = 16 - TYPE_W;
    localparam int PF_UP_W   = ADDR_W - MEM32_W;

    localparam logic [TYPE_W-1:0] TYPE_WIDE = TYPE_W'(1);

    typedef enum logic [CODE_W-1:0] {
        WIN_NONE    = 3'd0,
        WIN_IO      = 3'd1,
        WIN_MEM     = 3'd2,
        WIN_PREF    = 3'd3,
        WIN_VGA_IO  = 3'd4,
        WIN_VGA_MEM = 3'd5
    } win_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
    } window_t;

    localparam logic [ADDR_W-1:0] VGA_IO_LO_LO = 64'h3B0;
    localparam logic [ADDR_W-1:0] VGA_IO_LO_HI = 64'h3BB;
    localparam logic [ADDR_W-1:0] VGA_IO_HI_LO = 64'h3C0;
    localparam logic [ADDR_W-1:0] VGA_IO_HI_HI = 64'h3DF;
    localparam logic [ADDR_W-1:0] VGA_MEM_LO   = 64'hA0000;
    localparam logic [ADDR_W-1:0] VGA_MEM_HI   = 64'hBFFFF;

    // Slot order is the priority order: a lower slot index wins.
    localparam int SLOT_PREF    = 0;
    localparam int SLOT_MEM     = 1;
    localparam int SLOT_VGA_MEM = 2;
    localparam int SLOT_IO      = 3;
    localparam int SLOT_VGA_IO0 = 4;
    localparam int SLOT_VGA_IO1 = 5;

    // Returns the code reported for a slot.
    function automatic win_e slot_code(input int slot);
        case (slot)
            SLOT_PREF:    return WIN_PREF;
            SLOT_MEM:     return WIN_MEM;
            SLOT_VGA_MEM: return WIN_VGA_MEM;
            SLOT_IO:      return WIN_IO;
            default:      return WIN_VGA_IO;
        endcase
    endfunction

    // Returns 1 when the slot decodes I/O space.
    function automatic logic slot_is_io(input int slot);
        return (slot >= SLOT_IO);
    endfunction
endpackage

// File: rtl/bwd_window_build.sv
// Rebuilds the three programmable windows from the packed header fields.
// Assumes the low nibble of each packed base or limit field is a type code.
// The value 1 selects the wide form (32-bit I/O or 64-bit prefetchable);
// any other value selects the narrow form.
// The enable of each window is the matching command enable.
// A window whose limit is below its base is marked disabled here.
module bwd_window_build
    import bwd_pkg::*;
(
    input  logic                cmd_io_en,
    input  logic                cmd_mem_en,
    input  logic [7:0]          io_base_b,
    input  logic [7:0]          io_limit_b,
    input  logic [IO_UP_W-1:0]  io_base_hi,
    input  logic [IO_UP_W-1:0]  io_limit_hi,
    input  logic [15:0]         mem_base_w,
    input  logic [15:0]         mem_limit_w,
    input  logic [15:0]         pf_base_w,
    input  logic [15:0]         pf_limit_w,
    input  logic [PF_UP_W-1:0]  pf_base_hi,
    input  logic [PF_UP_W-1:0]  pf_limit_hi,
    output window_t             io_win,
    output window_t             mem_win,
    output window_t             pf_win
);
    logic [IO_W-1:0]    io_lo32, io_hi32;
    logic [MEM32_W-1:0] mem_lo32, mem_hi32;
    logic [ADDR_W-1:0]  pf_lo64, pf_hi64;

    // I/O bounds: 4 KB granularity, optional upper 16 bits.
    always_comb begin
        io_lo32 = {(io_base_b[TYPE_W-1:0] == TYPE_WIDE) ? io_base_hi : {IO_UP_W{1'b0}},
                   io_base_b[7:TYPE_W], {IO_GRAN_W{1'b0}}};
        io_hi32 = {(io_limit_b[TYPE_W-1:0] == TYPE_WIDE) ? io_limit_hi : {IO_UP_W{1'b0}},
                   io_limit_b[7:TYPE_W], {IO_GRAN_W{1'b1}}};
    end

    // Non-prefetchable memory bounds: 1 MB granularity, below 4 GB.
    always_comb begin
        mem_lo32 = {mem_base_w[15:TYPE_W], {MEM_GRAN_W{1'b0}}};
        mem_hi32 = {mem_limit_w[15:TYPE_W], {MEM_GRAN_W{1'b1}}};
    end

    // Prefetchable bounds: 1 MB granularity, optional upper 32 bits.
    always_comb begin
        pf_lo64 = {(pf_base_w[TYPE_W-1:0] == TYPE_WIDE) ? pf_base_hi : {PF_UP_W{1'b0}},
                   pf_base_w[15:TYPE_W], {MEM_GRAN_W{1'b0}}};
        pf_hi64 = {(pf_limit_w[TYPE_W-1:0] == TYPE_WIDE) ? pf_limit_hi : {PF_UP_W{1'b0}},
                   pf_limit_w[15:TYPE_W], {MEM_GRAN_W{1'b1}}};
    end

    // Packs each window with its enable and its ordering check.
    always_comb begin
        io_win.lo  = ADDR_W'(io_lo32);
        io_win.hi  = ADDR_W'(io_hi32);
        io_win.en  = cmd_io_en && (io_hi32 >= io_lo32);
        mem_win.lo = ADDR_W'(mem_lo32);
        mem_win.hi = ADDR_W'(mem_hi32);
        mem_win.en = cmd_mem_en && (mem_hi32 >= mem_lo32);
        pf_win.lo  = pf_lo64;
        pf_win.hi  = pf_hi64;
        pf_win.en  = cmd_mem_en && (pf_hi64 >= pf_lo64);
    end
endmodule

// File: rtl/bwd_range_match.sv
// Inclusive range comparator for one window.
// Assumes lo and hi have already been rebuilt.
// It reports a hit only when the window is enabled and lo <= addr <= hi.
module bwd_range_match #(
    parameter int W = 64
) (
    input  logic         en,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    input  logic [W-1:0] addr,
    output logic         hit
);
    // Inclusive bound compare, gated by the enable.
    always_comb hit = en && (addr >= lo) && (addr <= hi);
endmodule

// File: rtl/bwd_prio_sel.sv
// Priority selector over the window slots. The lowest set slot index wins,
// and its code comes from the package mapping. With no slot set, it gives
// the "none" code.
module bwd_prio_sel
    import bwd_pkg::*;
#(
    parameter int N = NWIN
) (
    input  logic [N-1:0] hits,
    output logic         any,
    output win_e         code
);
    // Walks from the weakest slot to the strongest, so the strongest is written last.
    always_comb begin
        code = WIN_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) code = slot_code(i);
        end
        any = |hits;
    end
endmodule

// File: rtl/bridge_window_decoder.sv
// Top of the bridge forwarding window decoder.
// Assumes the header values are stable while a request is decoded.
// A request is answered on the same clock edge that samples it.
// I/O requests compare only the low IO_W address bits. Memory requests
// compare the full address, so the 32-bit windows miss above 4 GB.
module bridge_window_decoder
    import bwd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_is_io,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                cmd_io_en,
    input  logic                cmd_mem_en,
    input  logic                vga_en,
    input  logic [7:0]          io_base_b,
    input  logic [7:0]          io_limit_b,
    input  logic [IO_UP_W-1:0]  io_base_hi,
    input  logic [IO_UP_W-1:0]  io_limit_hi,
    input  logic [15:0]         mem_base_w,
    input  logic [15:0]         mem_limit_w,
    input  logic [15:0]         pf_base_w,
    input  logic [15:0]         pf_limit_w,
    input  logic [PF_UP_W-1:0]  pf_base_hi,
    input  logic [PF_UP_W-1:0]  pf_limit_hi,
    output logic                rsp_valid,
    output logic                rsp_hit,
    output logic [CODE_W-1:0]   rsp_win
);
    window_t            io_win, mem_win, pf_win;
    window_t            slots [NWIN];
    logic [NWIN-1:0]    slot_hit;
    logic [ADDR_W-1:0]  io_addr;
    logic               sel_any;
    win_e               sel_code;

    bwd_window_build u_build (
        .cmd_io_en   (cmd_io_en),
        .cmd_mem_en  (cmd_mem_en),
        .io_base_b   (io_base_b),
        .io_limit_b  (io_limit_b),
        .io_base_hi  (io_base_hi),
        .io_limit_hi (io_limit_hi),
        .mem_base_w  (mem_base_w),
        .mem_limit_w (mem_limit_w),
        .pf_base_w   (pf_base_w),
        .pf_limit_w  (pf_limit_w),
        .pf_base_hi  (pf_base_hi),
        .pf_limit_hi (pf_limit_hi),
        .io_win      (io_win),
        .mem_win     (mem_win),
        .pf_win      (pf_win)
    );

    // Places programmable and fixed windows into their priority slots.
    always_comb begin
        slots[SLOT_PREF]    = pf_win;
        slots[SLOT_MEM]     = mem_win;
        slots[SLOT_VGA_MEM] = '{en: vga_en, lo: VGA_MEM_LO,   hi: VGA_MEM_HI};
        slots[SLOT_IO]      = io_win;
        slots[SLOT_VGA_IO0] = '{en: vga_en, lo: VGA_IO_LO_LO, hi: VGA_IO_LO_HI};
        slots[SLOT_VGA_IO1] = '{en: vga_en, lo: VGA_IO_HI_LO, hi: VGA_IO_HI_HI};
    end

    // I/O requests see only the low address bits.
    always_comb io_addr = ADDR_W'(req_addr[IO_W-1:0]);

    for (genvar gi = 0; gi < NWIN; gi++) begin : g_slot
        localparam logic IS_IO = slot_is_io(gi);
        bwd_range_match #(.W(ADDR_W)) u_match (
            .en   (slots[gi].en && (req_is_io == IS_IO)),
            .lo   (slots[gi].lo),
            .hi   (slots[gi].hi),
            .addr (IS_IO ? io_addr : req_addr),
            .hit  (slot_hit[gi])
        );
    end

    bwd_prio_sel #(.N(NWIN)) u_sel (
        .hits (slot_hit),
        .any  (sel_any),
        .code (sel_code)
    );

    // Registers the decision one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_win   <= WIN_NONE;
        end else begin
            rsp_valid <= req_valid;
            rsp_hit   <= req_valid && sel_any;
            rsp_win   <= req_valid ? sel_code : WIN_NONE;
        end
    end
endmodule

// File: rtl/bwd_checker.sv
// Temporal checks on the decoder's ports, bound to the top module.
module bwd_checker
    import bwd_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_is_io,
    input logic [ADDR_W-1:0]  req_addr,
    input logic               cmd_io_en,
    input logic               cmd_mem_en,
    input logic               vga_en,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic [CODE_W-1:0]  rsp_win
);
    logic in_vga_mem;
    always_comb in_vga_mem = (req_addr >= VGA_MEM_LO) && (req_addr <= VGA_MEM_HI);

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!rsp_valid && !rsp_hit && rsp_win == WIN_NONE));

    a_r2_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_hit && rsp_win == WIN_NONE));

    a_r4_upper_mem_only_pref: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_io && req_addr[ADDR_W-1:MEM32_W] != '0)
        |=> (rsp_win == WIN_NONE || rsp_win == WIN_PREF));

    a_r6_io_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_io && !cmd_io_en && !vga_en) |=> !rsp_hit);

    a_r6_mem_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_io && !cmd_mem_en && !vga_en) |=> !rsp_hit);

    a_r6_io_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_io)
        |=> (rsp_win == WIN_NONE || rsp_win == WIN_IO || rsp_win == WIN_VGA_IO));

    a_r8_vga_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_io && vga_en && !cmd_mem_en && in_vga_mem)
        |=> (rsp_hit && rsp_win == WIN_VGA_MEM));

    a_r9_hit_code: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit == (rsp_win != WIN_NONE));

    a_r9_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);
endmodule

bind bridge_window_decoder bwd_checker u_bwd_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_is_io  (req_is_io),
    .req_addr   (req_addr),
    .cmd_io_en  (cmd_io_en),
    .cmd_mem_en (cmd_mem_en),
    .vga_en     (vga_en),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_win    (rsp_win)
);

// File: tb/test_bridge_window_decoder.sv
module test_bridge_window_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_is_io = 1'b0;
    logic [63:0] req_addr = '0;
    logic        cmd_io_en = 1'b0, cmd_mem_en = 1'b0, vga_en = 1'b0;
    logic [7:0]  io_base_b = '0, io_limit_b = '0;
    logic [15:0] io_base_hi = '0, io_limit_hi = '0;
    logic [15:0] mem_base_w = '0, mem_limit_w = '0, pf_base_w = '0, pf_limit_w = '0;
    logic [31:0] pf_base_hi = '0, pf_limit_hi = '0;
    logic        rsp_valid, rsp_hit;
    logic [2:0]  rsp_win;

    int total = 0, bad = 0;
    bit done = 0;
    logic [4:0] exp_q[$];

    always #10 clk = ~clk;

    bridge_window_decoder i_bridge_window_decoder (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_io(req_is_io),
        .req_addr(req_addr), .cmd_io_en(cmd_io_en), .cmd_mem_en(cmd_mem_en),
        .vga_en(vga_en), .io_base_b(io_base_b), .io_limit_b(io_limit_b),
        .io_base_hi(io_base_hi), .io_limit_hi(io_limit_hi),
        .mem_base_w(mem_base_w), .mem_limit_w(mem_limit_w),
        .pf_base_w(pf_base_w), .pf_limit_w(pf_limit_w),
        .pf_base_hi(pf_base_hi), .pf_limit_hi(pf_limit_hi),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_win(rsp_win)
    );

    // Behavioural reference model built from the requirement text.
    function automatic void ref_decode(input logic io, input logic [63:0] a,
                                       output logic h, output logic [2:0] c);
        logic [63:0] a32, lo, hi;
        h = 0; c = 0;
        a32 = a & 64'hFFFF_FFFF;
        if (io) begin
            lo = 64'(io_base_b >> 4) * 64'h1000
               + ((io_base_b[3:0] == 4'd1) ? 64'(io_base_hi) * 64'h10000 : 64'h0);
            hi = 64'(io_limit_b >> 4) * 64'h1000 + 64'hFFF
               + ((io_limit_b[3:0] == 4'd1) ? 64'(io_limit_hi) * 64'h10000 : 64'h0);
            if (cmd_io_en && hi >= lo && a32 >= lo && a32 <= hi) begin h = 1; c = 1; end
            else if (vga_en && ((a32 >= 64'h3B0 && a32 <= 64'h3BB) ||
                                (a32 >= 64'h3C0 && a32 <= 64'h3DF))) begin h = 1; c = 4; end
        end else begin
            lo = 64'(pf_base_w >> 4) * 64'h100000
               + ((pf_base_w[3:0] == 4'd1) ? {pf_base_hi, 32'h0} : 64'h0);
            hi = 64'(pf_limit_w >> 4) * 64'h100000 + 64'hFFFFF
               + ((pf_limit_w[3:0] == 4'd1) ? {pf_limit_hi, 32'h0} : 64'h0);
            if (cmd_mem_en && hi >= lo && a >= lo && a <= hi) begin h = 1; c = 3; end
            else begin
                lo = 64'(mem_base_w >> 4) * 64'h100000;
                hi = 64'(mem_limit_w >> 4) * 64'h100000 + 64'hFFFFF;
                if (cmd_mem_en && hi >= lo && a >= lo && a <= hi) begin h = 1; c = 2; end
                else if (vga_en && a >= 64'hA0000 && a <= 64'hBFFFF) begin h = 1; c = 5; end
            end
        end
    endfunction

    task automatic check(input string req, input logic got_v, got_h,
                         input logic [2:0] got_c, input logic [4:0] e);
        total++;
        if ({got_v, got_h, got_c} !== e) begin
            bad++;
            $display("FAIL %s: got v=%0b hit=%0b win=%0d expected v=%0b hit=%0b win=%0d",
                     req, got_v, got_h, got_c, e[4], e[3], e[2:0]);
        end
    endtask

    // Drives one cycle from a negedge and compares the answer at the next negedge.
    task automatic cycle(input logic v, input logic io, input logic [63:0] a, input string req);
        logic h; logic [2:0] c;
        req_valid = v; req_is_io = io; req_addr = a;
        ref_decode(io, a, h, c);
        exp_q.push_back(v ? {1'b1, h, c} : 5'b0);
        @(negedge clk);
        check(req, rsp_valid, rsp_hit, rsp_win, exp_q.pop_front());
    endtask

    task automatic expect_code(input logic io, input logic [63:0] a,
                               input logic [2:0] code, input string req);
        logic h; logic [2:0] c;
        ref_decode(io, a, h, c);
        total++;
        if (c !== code) begin
            bad++;
            $display("FAIL %s model: got win=%0d expected win=%0d", req, c, code);
        end
        cycle(1'b1, io, a, req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset clears outputs even with a request present.
        req_valid = 1; req_is_io = 1; vga_en = 1; req_addr = 64'h3B0;
        repeat (3) @(negedge clk);
        check("R1", rsp_valid, rsp_hit, rsp_win, 5'b0);
        req_valid = 0; vga_en = 0;
        rst_n = 1;
        cycle(1'b0, 1'b0, 64'h0, "R2 idle");

        // R3: 32-bit I/O window 0x0001_2000..0x0001_3FFF.
        cmd_io_en = 1;
        io_base_b = 8'h21; io_base_hi = 16'h0001;
        io_limit_b = 8'h31; io_limit_hi = 16'h0001;
        expect_code(1, 64'h0001_1FFF, 0, "R3 base-1");
        expect_code(1, 64'h0001_2000, 1, "R3 base");
        expect_code(1, 64'h0001_3FFF, 1, "R3 limit");
        expect_code(1, 64'h0001_4000, 0, "R3 limit+1");
        expect_code(1, 64'hFFFF_FFFF_0001_2800, 1, "R3 upper ignored");
        expect_code(0, 64'h0001_2800, 0, "R6 memory request misses I/O window");
        // R3: narrow type drops the upper register.
        io_base_b = 8'h20; io_limit_b = 8'h30;
        expect_code(1, 64'h0000_2000, 1, "R3 16-bit base");
        expect_code(1, 64'h0000_3FFF, 1, "R3 16-bit limit");
        expect_code(1, 64'h0001_2000, 0, "R3 16-bit upper dropped");
        // R6: I/O enable off.
        cmd_io_en = 0;
        expect_code(1, 64'h0000_2000, 0, "R6 io disabled");
        // R7: limit below base.
        cmd_io_en = 1; io_base_b = 8'h50; io_limit_b = 8'h40;
        expect_code(1, 64'h0000_4800, 0, "R7 io inverted");
        expect_code(1, 64'h0000_5000, 0, "R7 io inverted base");

        // R4: memory window 0x1230_0000..0x124F_FFFF.
        cmd_mem_en = 1; mem_base_w = 16'h1230; mem_limit_w = 16'h1240;
        pf_base_w = 16'hFFF0; pf_limit_w = 16'h0000;
        expect_code(0, 64'h122F_FFFF, 0, "R4 base-1");
        expect_code(0, 64'h1230_0000, 2, "R4 base");
        expect_code(0, 64'h124F_FFFF, 2, "R4 limit");
        expect_code(0, 64'h1250_0000, 0, "R4 limit+1");
        expect_code(0, 64'h1_1230_0000, 0, "R4 above 4GB");
        expect_code(1, 64'h1230_0000, 0, "R6 io request misses memory window");
        cmd_mem_en = 0;
        expect_code(0, 64'h1230_0000, 0, "R6 mem disabled");
        cmd_mem_en = 1;

        // R5: 64-bit prefetchable 0x5_2000_0000..0x5_200F_FFFF.
        pf_base_w = 16'h2001; pf_limit_w = 16'h2001;
        pf_base_hi = 32'h5; pf_limit_hi = 32'h5;
        expect_code(0, 64'h5_1FFF_FFFF, 0, "R5 base-1");
        expect_code(0, 64'h5_2000_0000, 3, "R5 base");
        expect_code(0, 64'h5_200F_FFFF, 3, "R5 limit");
        expect_code(0, 64'h5_2010_0000, 0, "R5 limit+1");
        expect_code(0, 64'h0_2000_0000, 0, "R5 wrong upper");
        pf_base_w = 16'h2000; pf_limit_w = 16'h2000;
        expect_code(0, 64'h0_2000_0000, 3, "R5 32-bit type");
        expect_code(0, 64'h5_2000_0000, 0, "R5 32-bit upper dropped");
        // R9: prefetchable over memory.
        pf_base_w = 16'h1230; pf_limit_w = 16'h1230;
        expect_code(0, 64'h1230_0000, 3, "R9 pref beats mem");
        expect_code(0, 64'h1240_0000, 2, "R9 mem outside pref");

        // R8: legacy display ranges, command enables off.
        cmd_io_en = 0; cmd_mem_en = 0; vga_en = 1;
        expect_code(1, 64'h3AF, 0, "R8 io lo-1");
        expect_code(1, 64'h3B0, 4, "R8 io lo base");
        expect_code(1, 64'h3BB, 4, "R8 io lo limit");
        expect_code(1, 64'h3BC, 0, "R8 io lo limit+1");
        expect_code(1, 64'h3BF, 0, "R8 io hi-1");
        expect_code(1, 64'h3C0, 4, "R8 io hi base");
        expect_code(1, 64'h3DF, 4, "R8 io hi limit");
        expect_code(1, 64'h3E0, 0, "R8 io hi limit+1");
        expect_code(0, 64'h9FFFF, 0, "R8 mem-1");
        expect_code(0, 64'hA0000, 5, "R8 mem base");
        expect_code(0, 64'hBFFFF, 5, "R8 mem limit");
        expect_code(0, 64'hC0000, 0, "R8 mem limit+1");
        expect_code(0, 64'h1_000A_0000, 0, "R4 vga mem above 4GB");
        // R9: I/O window over VGA I/O.
        cmd_io_en = 1; io_base_b = 8'h00; io_limit_b = 8'h00;
        expect_code(1, 64'h3C0, 1, "R9 io beats vga");
        vga_en = 0;
        expect_code(0, 64'hA0000, 0, "R8 vga off");

        // R2: idle between requests.
        cycle(1'b0, 1'b0, 64'h1230_0000, "R2 idle after work");

        // R9: randomized comparison against the model every cycle.
        for (int k = 0; k < 400; k++) begin
            logic [63:0] a;
            cmd_io_en = 1'($urandom); cmd_mem_en = 1'($urandom); vga_en = 1'($urandom);
            io_base_b = {4'($urandom), 3'b0, 1'($urandom)};
            io_limit_b = {4'($urandom), 3'b0, 1'($urandom)};
            io_base_hi = 16'($urandom % 2); io_limit_hi = 16'($urandom % 2);
            mem_base_w = {12'($urandom % 8) << 4, 4'h0};
            mem_limit_w = {12'($urandom % 8) << 4, 4'h0};
            pf_base_w = {12'($urandom % 8) << 4, 3'b0, 1'($urandom)};
            pf_limit_w = {12'($urandom % 8) << 4, 3'b0, 1'($urandom)};
            pf_base_hi = 32'($urandom % 2); pf_limit_hi = 32'($urandom % 2);
            case ($urandom % 4)
                0: a = {32'($urandom % 2), 32'($urandom)};
                1: a = {32'($urandom % 2), 4'($urandom % 8), 28'($urandom)};
                2: a = 64'($urandom % 32'h0002_0000);
                default: a = 64'h3A0 + 64'($urandom % 32'h50);
            endcase
            cycle(1'($urandom % 8 != 0), 1'($urandom), a, "R9 random");
        end
        finish_run();
    end
endmodule